// File: doc/BRIEF.md
# Pulse Train Period and High-Time Capture

This block measures an external pulse train against one free-running timer counter. One input pin, picked from two, feeds two capture channels. The rise channel stores the counter value when the pin goes high. The fall channel stores it when the pin goes low. Each time the rise channel captures, the block pushes a two-word snapshot onto a valid/ready output: the new rise value and the most recent fall value. The snapshot stands in for a two-register burst read.

A consumer takes the snapshots in consecutive pairs. The period is the second rise value minus the first. The high time is the second fall value minus the first rise value. Both differences are taken modulo the counter's cycle length, so a counter wrap is harmless. The fall value in the first snapshot of a pair has no meaning.

Two prescalers are available. The clock prescaler slows the counter, which widens the window that can be measured. The edge prescaler captures only every 2nd, 4th or 8th edge, which averages out the counter's quantisation. A start pulse acts as the update event. It loads the settings, clears the counter and arms the channels. A stop pulse disarms the channels.

Top module: `pulse_capture`

## Requirements
- R1: Each accepted rising edge stores the counter into the rise register and produces a snapshot one clock later with `snap_rise` equal to that value and `snap_fall` equal to the fall register at that moment. In that snapshot, the fall value is the capture of the falling edge that followed the previous rise capture.
- R2: For two consecutive snapshots, (second `snap_rise` − first `snap_rise`) mod (reload+1) equals the input period expressed in counter ticks.
- R3: With edge code 0, (`snap_fall` of a snapshot − `snap_rise` of the previous snapshot) mod (reload+1) equals the input high time in counter ticks.
- R4: The counter advances once every psc+1 clocks. It counts 0..reload and then returns to 0, and all captured values stay within 0..reload.
- R5: The 2-bit edge code k (0,1,2,3) makes each channel capture only every 2^k-th qualifying edge. Its edge count restarts on start. Consecutive snapshots then differ by 2^k periods in both the rise and the fall value.
- R6: A start pulse without stop loads psc, reload, source select and edge code, zeroes the prescaler and counter, clears the capture registers, the pending snapshot and the overrun flag, and sets `running`. Configuration inputs are ignored while running until the next start.
- R7: Source select 0 measures `pin_a` and 1 measures `pin_b`. The other pin has no effect on the results.
- R8: `snap_valid` with its data holds until accepted by `snap_ready`. A new snapshot arriving while one is held and not accepted in that cycle sets the sticky `overrun` flag and replaces the held data. Only start clears `overrun`.
- R9: Stop, which wins over start, clears `running`. While not running, no edge is captured and no new snapshot appears.
- R10: After reset, `running`, `snap_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Update event and arm pulse |
| stop | input | 1 | Disarm pulse, priority over start |
| cfg_src | input | 1 | Source select: 0 pin_a, 1 pin_b |
| cfg_psc | input | PSC_W | Counter clock divider minus one |
| cfg_reload | input | CNT_W | Counter top value |
| cfg_ediv | input | 2 | Edge prescaler code k, capture every 2^k edges |
| pin_a | input | 1 | Asynchronous pulse input 0 |
| pin_b | input | 1 | Asynchronous pulse input 1 |
| running | output | 1 | Counter running and channels armed |
| snap_valid | output | 1 | Snapshot available |
| snap_ready | input | 1 | Snapshot accepted this cycle |
| snap_rise | output | CNT_W | Rise register value in snapshot |
| snap_fall | output | CNT_W | Fall register value in snapshot |
| overrun | output | 1 | A held snapshot was overwritten |

## Verification
Suppose the counter, the prescaler phase or an edge count goes wrong. The fault then shows up in the next snapshot pair as a period or high-time difference that is off by ticks, and a snapshot always arrives within 2^k input periods. A select or synchroniser fault shows as periods that match the unselected waveform, or as missing snapshots. A handshake fault shows within one input period: the data changes while held, or `overrun` stays clear. The sweep covers every clock prescaler from 0 to 2 and every edge code, with two input shapes each, and it forces counter wraps with a small reload.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef enum logic [1:0] {
        EDIV_1 = 2'd0,
        EDIV_2 = 2'd1,
        EDIV_4 = 2'd2,
        EDIV_8 = 2'd3
    } ediv_e;

    localparam int NUM_CH = 2;

    // last edge count value before a capture fires
    function automatic logic [2:0] ediv_last(ediv_e code);
        logic [2:0] one;
        one = 3'd1;
        return (one << code) - 3'd1;
    endfunction

endpackage

// File: rtl/pcap_sync_edge.sv
module pcap_sync_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pins_i,
    input  logic       load_i,
    input  logic       sel_i,
    output logic       rise_o,
    output logic       fall_o
);
    typedef struct packed {
        logic [1:0] s1;
        logic [1:0] s2;
        logic       sel;
        logic       prev;
    } se_s;

    se_s q, d;
    logic lvl;

    always_comb begin
        d      = q;
        d.s1   = pins_i;
        d.s2   = q.s1;
        lvl    = q.s2[q.sel];
        rise_o = lvl & ~q.prev;
        fall_o = ~lvl & q.prev;
        d.prev = lvl;
        if (load_i) begin
            d.sel  = sel_i;
            d.prev = q.s1[sel_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             halt_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rel_o
);
    typedef struct packed {
        logic             run;
        logic [PSC_W-1:0] psc;
        logic [PSC_W-1:0] pcnt;
        logic [CNT_W-1:0] rel;
        logic [CNT_W-1:0] cnt;
    } tb_s;

    tb_s q, d;

    always_comb begin
        d = q;
        if (halt_i) begin
            d.run = 1'b0;
        end else if (load_i) begin
            d.run  = 1'b1;
            d.psc  = psc_i;
            d.rel  = reload_i;
            d.pcnt = '0;
            d.cnt  = '0;
        end else if (q.run) begin
            if (q.pcnt == q.psc) begin
                d.pcnt = '0;
                d.cnt  = (q.cnt == q.rel) ? '0 : q.cnt + 1'b1;
            end else begin
                d.pcnt = q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o = q.run;
    assign cnt_o = q.cnt;
    assign rel_o = q.rel;
endmodule

// File: rtl/pcap_edge_div.sv
module pcap_edge_div
    import pcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] code_i,
    input  logic       en_i,
    input  logic       edge_i,
    output logic       fire_o
);
    typedef struct packed {
        logic [1:0] code;
        logic [2:0] n;
    } ed_s;

    ed_s q, d;

    always_comb begin
        d      = q;
        fire_o = en_i & edge_i & (q.n == ediv_last(ediv_e'(q.code)));
        if (load_i) begin
            d.code = code_i;
            d.n    = '0;
        end else if (en_i && edge_i) begin
            d.n = fire_o ? 3'd0 : q.n + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pulse_capture.sv
module pulse_capture
    import pcap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             cfg_src,
    input  logic [PSC_W-1:0] cfg_psc,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic [1:0]       cfg_ediv,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic             running,
    output logic             snap_valid,
    input  logic             snap_ready,
    output logic [CNT_W-1:0] snap_rise,
    output logic [CNT_W-1:0] snap_fall,
    output logic             overrun
);
    typedef struct packed {
        logic [CNT_W-1:0] cap_a;
        logic [CNT_W-1:0] cap_b;
        logic             sv;
        logic [CNT_W-1:0] sa;
        logic [CNT_W-1:0] sb;
        logic             ovr;
    } cap_s;

    cap_s q, d;

    logic              load_w;
    logic              rise_w, fall_w;
    logic [NUM_CH-1:0] edge_w;
    logic [NUM_CH-1:0] fire_w;
    logic [CNT_W-1:0]  count_w;
    logic [CNT_W-1:0]  reload_w;

    assign load_w = start & ~stop;
    assign edge_w = {fall_w, rise_w};

    pcap_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({pin_b, pin_a}),
        .load_i (load_w),
        .sel_i  (cfg_src),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    pcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tbase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .halt_i   (stop),
        .psc_i    (cfg_psc),
        .reload_i (cfg_reload),
        .run_o    (running),
        .cnt_o    (count_w),
        .rel_o    (reload_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pcap_edge_div u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .code_i (cfg_ediv),
            .en_i   (running),
            .edge_i (edge_w[ch]),
            .fire_o (fire_w[ch])
        );
    end

    always_comb begin
        d = q;
        if (fire_w[1]) d.cap_b = count_w;
        if (q.sv && snap_ready) d.sv = 1'b0;
        if (fire_w[0]) begin
            d.cap_a = count_w;
            if (q.sv && !snap_ready) d.ovr = 1'b1;
            d.sv = 1'b1;
            d.sa = count_w;
            d.sb = q.cap_b;
        end
        if (load_w) begin
            d.cap_a = '0;
            d.cap_b = '0;
            d.sv    = 1'b0;
            d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign snap_valid = q.sv;
    assign snap_rise  = q.sa;
    assign snap_fall  = q.sb;
    assign overrun    = q.ovr;
endmodule

// File: rtl/pulse_capture_chk.sv
module pulse_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             running,
    input logic             snap_valid,
    input logic             snap_ready,
    input logic             overrun,
    input logic             fire_rise,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rel
);
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        snap_valid && !snap_ready && !start |=> snap_valid);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !start |=> overrun);

    a_r9_idle_no_snap: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !snap_valid |=> !snap_valid);

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt <= rel);

    a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        running && !start |=> $stable(rel));

    a_r1_snap_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        fire_rise && !start |=> snap_valid);
endmodule

bind pulse_capture pulse_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .running    (running),
    .snap_valid (snap_valid),
    .snap_ready (snap_ready),
    .overrun    (overrun),
    .fire_rise  (fire_w[0]),
    .cnt        (count_w),
    .rel        (reload_w)
);

// File: tb/pulse_capture_bench.sv
`timescale 1ns/1ps
module pulse_capture_bench;
    localparam int CNT_W = 16;
    localparam int PSC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic             cfg_src = 1'b0;
    logic [PSC_W-1:0] cfg_psc = '0;
    logic [CNT_W-1:0] cfg_reload = '0;
    logic [1:0]       cfg_ediv = '0;
    logic             pin_a = 1'b0;
    logic             pin_b = 1'b0;
    logic             running;
    logic             snap_valid;
    logic             snap_ready = 1'b1;
    logic [CNT_W-1:0] snap_rise;
    logic [CNT_W-1:0] snap_fall;
    logic             overrun;

    pulse_capture #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_pulse_capture (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int nrec = 0;
    int ra [0:15];
    int rb [0:15];
    int gen_per = 10;
    int gen_hi = 4;
    bit gen_on_b = 1'b0;
    bit done = 1'b0;

    // waveform generator: main train on one pin, decoy train on the other
    initial begin
        int ph = 0;
        int ph2 = 0;
        logic lvl, lvl2;
        forever begin
            @(negedge clk);
            lvl  = (ph < gen_hi);
            lvl2 = (ph2 < 2);
            ph   = (ph + 1 >= gen_per) ? 0 : ph + 1;
            ph2  = (ph2 + 1 >= 7) ? 0 : ph2 + 1;
            pin_a = gen_on_b ? lvl2 : lvl;
            pin_b = gen_on_b ? lvl : lvl2;
        end
    end

    // snapshot recorder
    initial begin
        forever begin
            @(negedge clk);
            if (snap_valid && snap_ready && nrec < 16) begin
                ra[nrec] = int'(snap_rise);
                rb[nrec] = int'(snap_fall);
                nrec = nrec + 1;
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int moddiff(input int a, input int b, input int m);
        return (((b - a) % m) + m) % m;
    endfunction

    task automatic pulse_stop();
        @(posedge clk); #1 stop = 1'b1;
        @(posedge clk); #1 stop = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic arm(input int psc, input int rel, input int code, input bit src,
                       input int per, input int hi);
        pulse_stop();
        #1;
        gen_per  = per;
        gen_hi   = hi;
        gen_on_b = src;
        nrec     = 0;
        @(posedge clk); #1;
        cfg_psc    = PSC_W'(psc);
        cfg_reload = CNT_W'(rel);
        cfg_ediv   = 2'(code);
        cfg_src    = src;
        start      = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_snaps(input int n, input string req);
        int t;
        t = 0;
        while (nrec < n && t < 5000) begin
            @(posedge clk);
            t++;
        end
        if (nrec < n) check(1'b0, req, nrec, n);
    endtask

    initial begin
        int v1;
        bit wrapped;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(running == 1'b0, "R10 running after reset", int'(running), 0);
        check(snap_valid == 1'b0, "R10 snap_valid after reset", int'(snap_valid), 0);
        check(overrun == 1'b0, "R10 overrun after reset", int'(overrun), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // sweep: clock prescaler x edge code x input shape (R2 R3 R4 R5)
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int s = 0; s < 2; s++) begin
                    int tp, th, m;
                    tp = (s == 0) ? 5 : 9;
                    th = (s == 0) ? 2 : 4;
                    m  = 256;
                    arm(p, m - 1, k, 1'b0, tp * (p + 1), th * (p + 1));
                    wait_snaps(4, "R1 snapshot count");
                    check(moddiff(ra[1], ra[2], m) == tp * (1 << k), "R2 R4 R5 rise spacing",
                          moddiff(ra[1], ra[2], m), tp * (1 << k));
                    check(moddiff(rb[2], rb[3], m) == tp * (1 << k), "R5 fall spacing",
                          moddiff(rb[2], rb[3], m), tp * (1 << k));
                    if (k == 0)
                        check(moddiff(ra[1], rb[2], m) == th, "R3 R4 high time",
                              moddiff(ra[1], rb[2], m), th);
                end
            end
        end

        // wrap with a short counter cycle (R2 R3 R4)
        arm(0, 12, 0, 1'b0, 10, 3);
        wait_snaps(6, "R4 wrap snapshots");
        wrapped = 1'b0;
        for (int i = 1; i < 5; i++) begin
            check(moddiff(ra[i], ra[i+1], 13) == 10, "R2 period across wrap",
                  moddiff(ra[i], ra[i+1], 13), 10);
            check(moddiff(ra[i], rb[i+1], 13) == 3, "R3 high time across wrap",
                  moddiff(ra[i], rb[i+1], 13), 3);
            check(ra[i] <= 12, "R4 capture within reload", ra[i], 12);
            if (ra[i+1] < ra[i]) wrapped = 1'b1;
        end
        check(wrapped, "R4 counter wrapped to zero", int'(wrapped), 1);

        // source select: measure pin_b while pin_a carries a decoy (R7)
        arm(0, 255, 0, 1'b1, 8, 3);
        wait_snaps(4, "R7 snapshots");
        check(moddiff(ra[1], ra[2], 256) == 8, "R7 period from pin_b",
              moddiff(ra[1], ra[2], 256), 8);
        check(moddiff(ra[1], rb[2], 256) == 3, "R7 high from pin_b",
              moddiff(ra[1], rb[2], 256), 3);

        // configuration frozen while running (R6)
        arm(1, 255, 0, 1'b0, 10, 4);
        @(posedge clk); #1;
        cfg_psc = 8'd0; cfg_reload = 16'd5; cfg_src = 1'b1; cfg_ediv = 2'd3;
        wait_snaps(4, "R6 snapshots");
        check(moddiff(ra[1], ra[2], 256) == 5, "R6 period with old settings",
              moddiff(ra[1], ra[2], 256), 5);
        check(moddiff(ra[1], rb[2], 256) == 2, "R6 high with old settings",
              moddiff(ra[1], rb[2], 256), 2);

        // stall and overrun (R8)
        pulse_stop();
        #1 snap_ready = 1'b0;
        arm(0, 255, 0, 1'b0, 12, 5);
        begin
            int t;
            t = 0;
            @(negedge clk);
            while (!snap_valid && t < 200) begin
                @(negedge clk);
                t++;
            end
        end
        check(snap_valid == 1'b1, "R8 snapshot pending", int'(snap_valid), 1);
        v1 = int'(snap_rise);
        check(overrun == 1'b0, "R8 no overrun on first", int'(overrun), 0);
        repeat (5) @(negedge clk);
        check(snap_valid && int'(snap_rise) == v1, "R8 held until ready", int'(snap_rise), v1);
        repeat (11) @(negedge clk);
        check(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        check(moddiff(v1, int'(snap_rise), 256) == 12, "R8 newer replaces older",
              moddiff(v1, int'(snap_rise), 256), 12);
        @(posedge clk); #1 snap_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(snap_valid == 1'b0, "R8 accepted clears valid", int'(snap_valid), 0);
        check(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(overrun == 1'b0, "R8 R6 start clears overrun", int'(overrun), 0);

        // stop (R9)
        nrec = 0;
        wait_snaps(2, "R9 snapshots before stop");
        pulse_stop();
        #1 nrec = 0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(nrec == 0, "R9 no snapshots after stop", nrec, 0);
        check(running == 1'b0, "R9 running low after stop", int'(running), 0);

        report();
    end
endmodule